// File: doc/BRIEF.md
# Next Program Counter Logic

This block owns the instruction address of a single-cycle processor with fixed 32-bit instructions. It keeps the program counter in one register and, every cycle, forms the address of the following instruction from three candidates: the next sequential word, a conditional branch target relative to the sequential address, and an absolute jump target within the current 256 MiB region. The surrounding datapath fetches the instruction, decodes the branch and jump controls, and runs the equality subtraction in the ALU. Only the instruction word, those two control flags and the ALU zero flag reach this block.

The selection logic between register edges is combinational. The register loads the chosen candidate on every rising clock edge. A synchronous reset forces the counter to its start address. Two outputs are produced: the present counter and its sequential successor. The datapath uses the successor as the return or link value.

Top module: `pcn_next_pc`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is loaded with 0x00000000. This takes precedence over jump and branch requests presented in the same cycle.
- R2: With `jmp_en` low and no taken branch, the counter advances by 4 at each rising edge.
- R3: With `br_en` high, `alu_zero` high and `jmp_en` low, the next counter equals the current counter + 4 + (instruction bits 15:0, sign-extended, times 4). This holds for both positive and negative offsets.
- R4: With `br_en` high and `alu_zero` low, the branch is not taken and the counter advances by 4.
- R5: A high `alu_zero` with `br_en` low has no effect; the counter advances by 4.
- R6: With `jmp_en` high, the next counter is formed as follows: bits 31:28 come from the current counter, bits 27:2 come from instruction bits 25:0, and bits 1:0 are zero.
- R7: When `jmp_en` and a taken branch are requested together, the jump target wins.
- R8: Bits 1:0 of the counter are always zero.
- R9: `pc_plus4` always equals the current counter + 4 (modulo 2^32). It is taken from the present counter, not from any jump target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Current instruction word |
| br_en | input | 1 | Decoded equal-compare branch control |
| jmp_en | input | 1 | Decoded absolute jump control |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 |

## Verification
A corrupted counter shows up immediately on `pc_q`, and `pc_plus4` follows it within the same cycle. Every wrong selection is therefore visible one clock after the inputs that caused it. Because each next address is built from the present one, a single wrong step shifts every later address. The bench therefore compares both outputs against its own model on every cycle. Targeted sequences cover the following cases:
- a branch offset that crosses a 256 MiB boundary downward,
- a sequential step that crosses one upward,
- a jump made from a non-zero upper region, so that a swapped or dropped source of the top four bits is caught.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JIDX_W  = 26;
    localparam int unsigned ALIGN_W = 2;
    localparam int unsigned HI_W    = ADDR_W - JIDX_W - ALIGN_W;
    localparam int unsigned EXT_W   = ADDR_W - IMM_W - ALIGN_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SEL_SEQ = 2'd0,
        SEL_BR  = 2'd1,
        SEL_JMP = 2'd2
    } next_sel_e;

    typedef struct packed {
        addr_t seq;
        addr_t br;
        addr_t jmp;
    } pc_cand_t;

    function automatic addr_t word_offset(input logic [IMM_W-1:0] imm);
        return {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    endfunction

    function automatic addr_t region_jump(input addr_t base,
                                          input logic [JIDX_W-1:0] idx);
        return {base[ADDR_W-1 -: HI_W], idx, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pcn_seq_adder.sv
module pcn_seq_adder
    import pcn_pkg::*;
#(
    parameter int unsigned STEP = 4
) (
    input  addr_t pc,
    output addr_t seq
);
    localparam addr_t STEP_V = addr_t'(STEP);

    assign seq = pc + STEP_V;

endmodule

// File: rtl/pcn_target_gen.sv
module pcn_target_gen
    import pcn_pkg::*;
(
    input  addr_t             pc,
    input  addr_t             seq,
    input  logic [ADDR_W-1:0] instr,
    output addr_t             br_tgt,
    output addr_t             jmp_tgt
);
    logic [IMM_W-1:0]  imm_f;
    logic [JIDX_W-1:0] idx_f;

    assign imm_f   = instr[IMM_W-1:0];
    assign idx_f   = instr[JIDX_W-1:0];
    assign br_tgt  = seq + word_offset(imm_f);
    assign jmp_tgt = region_jump(pc, idx_f);

endmodule

// File: rtl/pcn_select.sv
module pcn_select
    import pcn_pkg::*;
(
    input  logic      br_en,
    input  logic      jmp_en,
    input  logic      alu_zero,
    input  pc_cand_t  cand,
    output next_sel_e sel,
    output addr_t     nxt
);
    logic br_taken;

    assign br_taken = br_en & alu_zero;

    always_comb begin
        if (jmp_en)
            sel = SEL_JMP;
        else if (br_taken)
            sel = SEL_BR;
        else
            sel = SEL_SEQ;
    end

    always_comb begin
        unique case (sel)
            SEL_JMP: nxt = cand.jmp;
            SEL_BR:  nxt = cand.br;
            default: nxt = cand.seq;
        endcase
    end

endmodule

// File: rtl/pcn_next_pc.sv
module pcn_next_pc
    import pcn_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic        br_en,
    input  logic        jmp_en,
    input  logic        alu_zero,
    output logic [31:0] pc_q,
    output logic [31:0] pc_plus4
);
    addr_t     pc_r;
    addr_t     seq_a;
    addr_t     br_a;
    addr_t     jmp_a;
    addr_t     nxt_a;
    pc_cand_t  cand;
    next_sel_e sel;

    pcn_seq_adder #(.STEP(4)) u_seq (
        .pc  (pc_r),
        .seq (seq_a)
    );

    pcn_target_gen u_tgt (
        .pc      (pc_r),
        .seq     (seq_a),
        .instr   (instr),
        .br_tgt  (br_a),
        .jmp_tgt (jmp_a)
    );

    assign cand = '{seq: seq_a, br: br_a, jmp: jmp_a};

    pcn_select u_sel (
        .br_en    (br_en),
        .jmp_en   (jmp_en),
        .alu_zero (alu_zero),
        .cand     (cand),
        .sel      (sel),
        .nxt      (nxt_a)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_r <= addr_t'(RESET_ADDR);
        else
            pc_r <= nxt_a;
    end

    assign pc_q     = pc_r;
    assign pc_plus4 = seq_a;

    // R1: reset loads the start address whatever the controls say
    a_r1_reset_start: assert property (@(posedge clk)
        rst |=> pc_q == RESET_ADDR);

    // R2: plain sequential step
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en && !br_en) |=> pc_q == $past(pc_q) + 32'd4);

    // R4: branch not taken when the compare was unequal
    a_r4_br_untaken: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en && br_en && !alu_zero) |=> pc_q == $past(pc_plus4));

    // R5: zero flag alone does nothing
    a_r5_zero_ignored: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en && !br_en && alu_zero) |=> pc_q == $past(pc_plus4));

    // R3: taken branch lands on successor plus scaled offset
    a_r3_br_taken: assert property (@(posedge clk) disable iff (rst)
        (!jmp_en && br_en && alu_zero) |=>
            pc_q == $past(pc_plus4) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // R6, R7: jump keeps region bits and wins over a branch
    a_r6_r7_jump: assert property (@(posedge clk) disable iff (rst)
        jmp_en |=> pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00});

    // R8: word alignment
    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);

    // R9: successor output tracks the counter
    a_r9_plus4: assert property (@(posedge clk) disable iff (rst)
        pc_plus4 - pc_q == 32'd4);

endmodule

// File: tb/pcn_next_pc_test.sv
module pcn_next_pc_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        br_en;
    logic        jmp_en;
    logic        alu_zero;
    logic [31:0] pc_q;
    logic [31:0] pc_plus4;

    int checks = 0;
    int errors = 0;
    logic [31:0] ref_pc;
    bit done = 0;

    always #5 clk = ~clk;

    pcn_next_pc uut (
        .clk      (clk),
        .rst      (rst),
        .instr    (instr),
        .br_en    (br_en),
        .jmp_en   (jmp_en),
        .alu_zero (alu_zero),
        .pc_q     (pc_q),
        .pc_plus4 (pc_plus4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare after the next falling edge
    task automatic step(input logic [31:0] w, input logic b, input logic j,
                        input logic z, input string req);
        logic [31:0] nxt;
        instr = w; br_en = b; jmp_en = j; alu_zero = z;
        if (j)
            nxt = {ref_pc[31:28], w[25:0], 2'b00};
        else if (b && z)
            nxt = ref_pc + 32'd4 + ($signed({{16{w[15]}}, w[15:0]}) * 4);
        else
            nxt = ref_pc + 32'd4;
        @(posedge clk);
        @(negedge clk);
        ref_pc = nxt;
        check(req, pc_q, ref_pc);
        check("R9", pc_plus4, ref_pc + 32'd4);
        check("R8", {30'd0, pc_q[1:0]}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; instr = '0; br_en = 0; jmp_en = 0; alu_zero = 0;
        repeat (3) @(negedge clk);
        ref_pc = 32'h0;
        check("R1", pc_q, 32'h0);
        check("R9", pc_plus4, 32'h4);
        rst = 1'b0;

        step(32'h0, 0, 0, 0, "R2");
        step(32'hDEAD_BEEF, 0, 0, 0, "R2");
        step(32'h0000_0010, 1, 0, 1, "R3");          // forward +64
        step(32'h0000_FFFC, 1, 0, 1, "R3");          // backward -16
        step(32'h0000_0100, 1, 0, 0, "R4");
        step(32'h0000_0100, 0, 0, 1, "R5");
        step(32'h03FF_FFFF, 0, 1, 0, "R6");          // to 0x0FFFFFFC
        step(32'h0, 0, 0, 0, "R2");                  // crosses into region 1
        check("R2", pc_q, 32'h1000_0000);
        step(32'h0000_FFFE, 1, 0, 1, "R3");          // -8 back below boundary
        check("R3", pc_q, 32'h0FFF_FFFC);
        step(32'h0, 0, 0, 0, "R2");
        step(32'h0000_1234, 0, 1, 0, "R6");          // keeps region 1
        check("R6", pc_q, 32'h1000_48D0);
        step(32'h0000_0040, 1, 1, 1, "R7");          // jump beats branch
        check("R7", pc_q, 32'h1000_0100);

        // reset beats a pending jump
        @(negedge clk);
        rst = 1'b1; jmp_en = 1'b1; br_en = 1'b1; alu_zero = 1'b1; instr = 32'h0155_5555;
        @(posedge clk);
        @(negedge clk);
        ref_pc = 32'h0;
        check("R1", pc_q, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 300; i++) begin
            logic [31:0] w;
            logic b, j, z;
            string tag;
            w = $urandom; b = 1'($urandom); j = 1'($urandom_range(0, 3) == 0); z = 1'($urandom);
            if (j && b && z)  tag = "R7";
            else if (j)       tag = "R6";
            else if (b && z)  tag = "R3";
            else if (b)       tag = "R4";
            else if (z)       tag = "R5";
            else              tag = "R2";
            step(w, b, j, z, tag);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule